// File: doc/BRIEF.md
# Conditional Skip Micro-Op Unit

This unit executes the conditional-skip family of operate microinstructions for a 12-bit accumulator machine. When a word from this family arrives with a valid strobe, the unit can test three conditions: accumulator negative, accumulator zero and link set. It ORs together the tests the word selects and applies a sense bit that can invert the result. The outcome is a one-cycle skip pulse, which the sequencer turns into an extra program-counter increment.

The same word can also clear the accumulator, OR a switch-register value into it, and raise a one-cycle halt request. All outputs are registered and appear one clock after the valid cycle. The accumulator result holds between valid cycles. A valid word from any other instruction family passes the accumulator through unchanged and raises nothing. Program-counter storage and the other operate family belong to neighbouring blocks.

Top module: `skip_micro_unit`

## Requirements
- R1: While `rst_n` is low, and right after reset, `acc_out` is 0 and `skip_pulse` and `halt_req` are 0.
- R2: A word is acted on only when bits 11..9 equal 7 (octal), bit 8 is 1 and bit 0 is 0. Any other valid word loads `acc_in` unchanged into `acc_out` and produces no skip and no halt.
- R3: Bit 6 selects the negative test, which is true when bit 11 of `acc_in` is 1.
- R4: Bit 5 selects the zero test, which is true when `acc_in` equals 0.
- R5: Bit 4 selects the link test, which is true when `link_in` is 1.
- R6: The selected tests are ORed. With bit 3 at 0 the unit skips when any selected test is true. With bit 3 at 1 it skips when no selected test is true. So with no test selected, bit 3 at 1 always skips and bit 3 at 0 never does.
- R7: Bit 7 clears the accumulator. The tests still see the `acc_in` value from before the clear.
- R8: Bit 2 ORs `switch_in` into the accumulator after any clear, so bits 7 and 2 together load the switch value.
- R9: Bit 1 raises `halt_req` for one cycle.
- R10: Results appear on the clock edge that samples `valid_in` high. `skip_pulse` and `halt_req` last one cycle. With `valid_in` low, no pulse is raised and `acc_out` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Instruction word and operands are valid this cycle |
| instr_in | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link flag |
| switch_in | input | 12 | Switch register value |
| acc_out | output | 12 | New accumulator value, registered |
| skip_pulse | output | 1 | One-cycle request to skip the next instruction |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The bench builds the unit with the default word width of 12. At that width the opcode field, the family-select bit and the eight micro-op bits all sit at their fixed positions, so every encoding used in the requirements can be driven directly. Directed words cover each test in both polarities, the empty-selection corner in both senses, clear-before-test ordering, clear-then-OR ordering, and words from other families. A long run of random words, half of them inside the family, is then compared cycle by cycle against a behavioural model.

// File: rtl/skip_micro_pkg.sv
package skip_micro_pkg;

  // micro-op bit positions inside the low byte of the word
  localparam int unsigned POS_CLEAR  = 7;
  localparam int unsigned POS_NEG    = 6;
  localparam int unsigned POS_ZERO   = 5;
  localparam int unsigned POS_LINK   = 4;
  localparam int unsigned POS_INVERT = 3;
  localparam int unsigned POS_SWITCH = 2;
  localparam int unsigned POS_HALT   = 1;
  localparam int unsigned POS_GROUP0 = 0;

  localparam int unsigned OPC_W      = 3;
  localparam logic [OPC_W-1:0] OPC_OPERATE = 3'b111;

  typedef struct packed {
    logic test_neg;
    logic test_zero;
    logic test_link;
    logic invert;
    logic clear;
    logic or_switch;
    logic halt;
  } micro_ops_t;

endpackage

// File: rtl/skip_decode.sv
module skip_decode
  import skip_micro_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic [WORD_W-1:0] instr_i,
  output logic              member_o,
  output micro_ops_t        ops_o
);
  localparam int unsigned OPC_HI  = WORD_W - 1;
  localparam int unsigned OPC_LO  = WORD_W - OPC_W;
  localparam int unsigned GRP_BIT = WORD_W - OPC_W - 1;

  function automatic logic in_family(input logic [WORD_W-1:0] w);
    return (w[OPC_HI:OPC_LO] == OPC_OPERATE) && w[GRP_BIT] && !w[POS_GROUP0];
  endfunction

  always_comb begin
    member_o        = in_family(instr_i);
    ops_o.test_neg  = instr_i[POS_NEG];
    ops_o.test_zero = instr_i[POS_ZERO];
    ops_o.test_link = instr_i[POS_LINK];
    ops_o.invert    = instr_i[POS_INVERT];
    ops_o.clear     = instr_i[POS_CLEAR];
    ops_o.or_switch = instr_i[POS_SWITCH];
    ops_o.halt      = instr_i[POS_HALT];
  end
endmodule

// File: rtl/skip_cond.sv
module skip_cond
  import skip_micro_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic [WORD_W-1:0] acc_i,
  input  logic              link_i,
  input  micro_ops_t        ops_i,
  output logic              any_hit_o,
  output logic              skip_o
);
  localparam int unsigned SIGN_BIT = WORD_W - 1;

  function automatic logic cond_any(input logic [WORD_W-1:0] a, input logic l,
                                    input micro_ops_t o);
    logic neg_t, zero_t, link_t;
    neg_t  = o.test_neg  && a[SIGN_BIT];
    zero_t = o.test_zero && (a == '0);
    link_t = o.test_link && l;
    return neg_t || zero_t || link_t;
  endfunction

  always_comb begin
    any_hit_o = cond_any(acc_i, link_i, ops_i);
    skip_o    = any_hit_o ^ ops_i.invert;
  end
endmodule

// File: rtl/acc_merge.sv
module acc_merge
  import skip_micro_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] switch_i,
  input  micro_ops_t        ops_i,
  output logic [WORD_W-1:0] acc_o
);
  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] s,
                                              input logic clr, input logic osr);
    logic [WORD_W-1:0] t;
    t = clr ? '0 : a;
    if (osr) t = t | s;
    return t;
  endfunction

  always_comb acc_o = merge(acc_i, switch_i, ops_i.clear, ops_i.or_switch);
endmodule

// File: rtl/skip_micro_unit.sv
module skip_micro_unit
  import skip_micro_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [WORD_W-1:0] instr_in,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              link_in,
  input  logic [WORD_W-1:0] switch_in,
  output logic [WORD_W-1:0] acc_out,
  output logic              skip_pulse,
  output logic              halt_req
);
  logic              is_member;
  micro_ops_t        ops;
  logic              any_hit;
  logic              skip_want;
  logic [WORD_W-1:0] acc_next;
  logic              fire;
  logic              no_test_sel;

  skip_decode #(.WORD_W(WORD_W)) u_dec (
    .instr_i (instr_in),
    .member_o(is_member),
    .ops_o   (ops)
  );

  skip_cond #(.WORD_W(WORD_W)) u_cond (
    .acc_i    (acc_in),
    .link_i   (link_in),
    .ops_i    (ops),
    .any_hit_o(any_hit),
    .skip_o   (skip_want)
  );

  acc_merge #(.WORD_W(WORD_W)) u_acc (
    .acc_i   (acc_in),
    .switch_i(switch_in),
    .ops_i   (ops),
    .acc_o   (acc_next)
  );

  assign fire        = valid_in && is_member;
  assign no_test_sel = !(ops.test_neg || ops.test_zero || ops.test_link);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out    <= '0;
      skip_pulse <= 1'b0;
      halt_req   <= 1'b0;
    end else begin
      skip_pulse <= fire && skip_want;
      halt_req   <= fire && ops.halt;
      if (valid_in) acc_out <= is_member ? acc_next : acc_in;
    end
  end

  // pulses only follow a valid cycle
  assert_skip_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> $past(valid_in));
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(acc_out));
  assert_halt_from_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(valid_in && instr_in[POS_HALT]));
  // words outside the family are inert
  assert_foreign_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !is_member) |=> (!skip_pulse && !halt_req));
  assert_foreign_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !is_member) |=> (acc_out == $past(acc_in)));
  // empty selection: the sense bit alone decides
  assert_empty_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && no_test_sel) |=> (skip_pulse == $past(ops.invert)));
  // a hit with normal sense always skips
  assert_hit_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && any_hit && !ops.invert) |=> skip_pulse);
  assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ops.clear && !ops.or_switch) |=> (acc_out == '0));
  assert_clear_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ops.clear && ops.or_switch) |=> (acc_out == $past(switch_in)));
endmodule

// File: tb/skip_micro_unit_test.sv
module skip_micro_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [11:0] instr_in = '0;
  logic [11:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] switch_in = '0;
  logic [11:0] acc_out;
  logic        skip_pulse;
  logic        halt_req;

  int checks = 0;
  int bad = 0;
  int exp_acc = 0;
  int exp_skip = 0;
  int exp_halt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_micro_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .instr_in(instr_in),
    .acc_in(acc_in), .link_in(link_in), .switch_in(switch_in),
    .acc_out(acc_out), .skip_pulse(skip_pulse), .halt_req(halt_req)
  );

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, expv);
    end
  endtask

  // behavioural reference, written with integer arithmetic
  task automatic model(input int v, input int w, input int a, input int l, input int s);
    int hits, fam;
    fam = ((w / 512) == 7) && ((w / 256) % 2 == 1) && (w % 2 == 0);
    exp_skip = 0;
    exp_halt = 0;
    if (v != 0) begin
      if (fam != 0) begin
        hits = 0;
        if ((w & 'o100) != 0 && a >= 2048) hits = 1;
        if ((w & 'o040) != 0 && a == 0) hits = 1;
        if ((w & 'o020) != 0 && l == 1) hits = 1;
        if ((w & 'o010) != 0) exp_skip = (hits == 0) ? 1 : 0;
        else exp_skip = hits;
        exp_acc = ((w & 'o200) != 0) ? 0 : a;
        if ((w & 'o004) != 0) exp_acc = exp_acc | s;
        exp_halt = ((w & 'o002) != 0) ? 1 : 0;
      end else begin
        exp_acc = a;
      end
    end
  endtask

  task automatic step(input string tag, input int v, input int w, input int a,
                      input int l, input int s);
    @(negedge clk);
    valid_in  = (v != 0);
    instr_in  = w[11:0];
    acc_in    = a[11:0];
    link_in   = l[0];
    switch_in = s[11:0];
    @(posedge clk);
    model(v, w, a, l, s);
    #(CLK_PERIOD/4);
    chk(tag, "acc", int'(acc_out), exp_acc);
    chk(tag, "skip", int'(skip_pulse), exp_skip);
    chk(tag, "halt", int'(halt_req), exp_halt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "acc in reset", int'(acc_out), 0);
    chk("R1", "skip in reset", int'(skip_pulse), 0);
    chk("R1", "halt in reset", int'(halt_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 'o7402, 'o1234, 1, 0);

    // R3 negative test
    step("R3", 1, 'o7500, 'o4000, 0, 0);
    step("R3", 1, 'o7500, 'o3777, 0, 0);
    // R4 zero test
    step("R4", 1, 'o7440, 0, 0, 0);
    step("R4", 1, 'o7440, 1, 0, 0);
    // R5 link test
    step("R5", 1, 'o7420, 'o0055, 1, 0);
    step("R5", 1, 'o7420, 'o0055, 0, 0);
    // R6 combine and sense
    step("R6", 1, 'o7560, 'o4000, 0, 0);
    step("R6", 1, 'o7510, 'o0001, 0, 0);
    step("R6", 1, 'o7510, 'o4001, 0, 0);
    step("R6", 1, 'o7410, 'o0007, 1, 0);
    step("R6", 1, 'o7400, 0, 1, 0);
    step("R6", 1, 'o7470, 'o0001, 0, 0);
    // R7 clear, tests see old value
    step("R7", 1, 'o7640, 0, 0, 0);
    step("R7", 1, 'o7640, 'o0005, 0, 0);
    step("R7", 1, 'o7700, 'o4321, 0, 0);
    // R8 switch OR after clear
    step("R8", 1, 'o7604, 'o7777, 0, 'o1234);
    step("R8", 1, 'o7404, 'o0300, 0, 'o0011);
    // R9 halt, R10 one-cycle pulse and hold
    step("R9", 1, 'o7402, 'o0042, 0, 0);
    step("R10", 0, 'o7402, 'o1111, 0, 0);
    step("R10", 0, 'o7410, 'o2222, 1, 0);
    // R2 foreign words
    step("R2", 1, 'o7603, 'o0707, 0, 'o7777);
    step("R2", 1, 'o7212, 'o0070, 0, 0);
    step("R2", 1, 'o3612, 'o4000, 1, 0);
    step("R2", 1, 'o6410, 'o1357, 0, 0);

    // random traffic, mostly inside the family
    for (int i = 0; i < 2000; i++) begin
      int w;
      w = int'($urandom_range(0, 4095));
      if ($urandom_range(0, 1) == 1) w = 'o7400 | (w & 'o376);
      step("R10", int'($urandom_range(0, 3) != 0), w, int'($urandom_range(0, 4095)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 4095)));
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule